// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sequences the operating and low-power modes of a small microcontroller and picks the source and divide ratio of its CPU clock. Software asks for a running mode (full-speed main clock, main clock divided down, phase-locked multiplier, slow sub clock or internal oscillator). It can also request a wait, which gates only the CPU clock, or a stop, which halts every oscillator. The controller checks each request against the allowed transitions. A request that is not allowed leaves the mode as it is and sets a sticky error flag.

Stop ends on a non-maskable interrupt, a low-voltage interrupt or a qualified peripheral interrupt. The oscillator that the CPU was using before the stop is restarted, with the divide ratio that applies after wake-up. The CPU clock gate stays closed for a programmable settling count. When it reopens, a one-cycle wake event is raised. Wait ends on any of the same interrupts. Every change to source, ratio or gate takes place on a divided-clock boundary, so the gated clock downstream never sees a runt pulse. The synchronous reset input acts as the hardware reset and returns the block to its default running mode from any state.

Top module: `lpm_clkctl`

## Requirements
- R1: After reset, the controller runs from the main clock (select 0) with divide ratio 8. Only the main oscillator enable is high, the CPU clock gate is open, and both the wake event and the error flag are low.
- R2: The mode codes are 0 = main/1 (select 0), 1 = PLL/1 (select 3, PLL and main oscillator both enabled), 2 = sub/1 (select 1), 3 = on-chip oscillator/1 (select 2) and 4 = main/8 (select 0). Code 1 is accepted only from main/1, and only code 0 is accepted while in PLL mode. Codes 5 to 7 are illegal.
- R3: A wait strobe closes the CPU clock gate and leaves the oscillators and the clock select unchanged. A qualifying interrupt reopens the gate in the same mode, and the wake event is high for exactly that one cycle.
- R4: An accepted stop request drops every oscillator enable and the CPU clock gate. They stay low until a wake source or reset arrives.
- R5: A wait or stop request made in PLL mode is refused, and so is a stop request while the oscillation-stop detection enable is high. A refused request keeps the mode and gate unchanged and sets the error flag.
- R6: A peripheral interrupt qualifies as a wake source only when its 3-bit level is nonzero and the global interrupt enable is high. NMI and low-voltage interrupts always qualify.
- R7: After a stop, the mode resumes from the pre-stop source. Main resumes as main/8, sub as sub/1, and on-chip oscillator as on-chip oscillator/8.
- R8: On wake from stop, the CPU clock gate reopens exactly stabilization count + 1 cycles after the oscillator enable rises. The wake event is high in that cycle only.
- R9: Mode, ratio and gate changes happen only at a divided-clock boundary. In a divide-by-8 mode entered at edge X, a request presented just after X takes effect at edge X+8.
- R10: The error flag is sticky. It is cleared by a cycle with the clear input high, and a refused request in the same cycle wins over the clear.
- R11: Reset issued while stopped or waiting restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| stop_req_i | input | 1 | One-cycle stop request |
| wait_req_i | input | 1 | One-cycle wait-instruction strobe |
| mode_req_valid_i | input | 1 | One-cycle mode change request |
| mode_req_code_i | input | 3 | Requested mode code (see R2) |
| nmi_i | input | 1 | Non-maskable interrupt |
| lvd_irq_i | input | 1 | Low-voltage interrupt |
| per_irq_i | input | NIRQ | Peripheral interrupt requests |
| per_lvl_i | input | NIRQ*LVL_W | Priority level per peripheral, irq g at bits [g*LVL_W +: LVL_W] |
| gie_i | input | 1 | Global interrupt enable |
| osc_det_en_i | input | 1 | Oscillation-stop detection enable |
| err_clr_i | input | 1 | Clears the error flag |
| stab_cycles_i | input | STAB_W | Settling count after stop |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub oscillator enable |
| oco_en_o | output | 1 | On-chip oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| clk_sel_o | output | 2 | Clock mux select |
| div_ratio_o | output | DIV_W | Divide ratio (1 or SLOW_DIV) |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| wake_o | output | 1 | One-cycle wake event |
| illegal_o | output | 1 | Sticky illegal-request flag |

## Verification
The bench targets the refusals: entering PLL from a non-main mode, leaving PLL for anything but main/1, and wait or stop from PLL. A design that skipped these checks would change the clock select or close the gate, and the bench would see that. It also targets peripheral interrupts with level zero or with the global enable low. A design that qualified them loosely would reopen the gate during wait or stop. The wake-up source and ratio are checked for main, sub and internal oscillator, with a zero and a nonzero settling count. An off-by-one timer or a wrong post-stop divider shows up there as a wrong cycle count or a wrong ratio. The last check counts edges in a divide-by-8 mode, and a design that applied changes without waiting for the boundary would respond after one or two cycles instead of eight.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_SUB  = 2'd1,
    SRC_OCO  = 2'd2,
    SRC_PLL  = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_STOP = 2'd2,
    ST_STAB = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    RQ_NONE = 2'd0,
    RQ_MODE = 2'd1,
    RQ_WAIT = 2'd2,
    RQ_STOP = 2'd3
  } req_kind_e;

  typedef struct packed {
    clk_src_e src;
    logic     slow;
  } clk_cfg_t;

  localparam logic [2:0] MODE_HS  = 3'd0;
  localparam logic [2:0] MODE_PLL = 3'd1;
  localparam logic [2:0] MODE_LS  = 3'd2;
  localparam logic [2:0] MODE_OCO = 3'd3;
  localparam logic [2:0] MODE_MED = 3'd4;
endpackage

// File: rtl/lpm_divider.sv
module lpm_divider #(
  parameter int SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt;

  // boundary: last cycle of a divided period (every cycle when undivided)
  assign tick_o = run_i && (slow_i ? (cnt == LAST) : 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel #(
  parameter int NIRQ  = 4,
  parameter int LVL_W = 3
) (
  input  logic [NIRQ-1:0]       per_irq_i,
  input  logic [NIRQ*LVL_W-1:0] per_lvl_i,
  input  logic                  gie_i,
  input  logic                  nmi_i,
  input  logic                  lvd_i,
  output logic                  any_wake_o
);
  logic [NIRQ-1:0] elig;

  for (genvar g = 0; g < NIRQ; g++) begin : g_elig
    assign elig[g] = per_irq_i[g] && (per_lvl_i[g*LVL_W +: LVL_W] != '0);
  end

  assign any_wake_o = nmi_i | lvd_i | (gie_i & (|elig));
endmodule

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
  parameter int STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [STAB_W-1:0] val_i,
  output logic              done_o
);
  logic [STAB_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/lpm_clkctl.sv
module lpm_clkctl
  import lpm_pkg::*;
#(
  parameter int NIRQ     = 4,
  parameter int LVL_W    = 3,
  parameter int STAB_W   = 8,
  parameter int SLOW_DIV = 8,
  localparam int DIV_W   = $clog2(SLOW_DIV + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stop_req_i,
  input  logic                  wait_req_i,
  input  logic                  mode_req_valid_i,
  input  logic [2:0]            mode_req_code_i,
  input  logic                  nmi_i,
  input  logic                  lvd_irq_i,
  input  logic [NIRQ-1:0]       per_irq_i,
  input  logic [NIRQ*LVL_W-1:0] per_lvl_i,
  input  logic                  gie_i,
  input  logic                  osc_det_en_i,
  input  logic                  err_clr_i,
  input  logic [STAB_W-1:0]     stab_cycles_i,
  output logic                  main_osc_en_o,
  output logic                  sub_osc_en_o,
  output logic                  oco_en_o,
  output logic                  pll_en_o,
  output logic [1:0]            clk_sel_o,
  output logic [DIV_W-1:0]      div_ratio_o,
  output logic                  cpu_clk_en_o,
  output logic                  wake_o,
  output logic                  illegal_o
);
  pwr_state_e st, st_n;
  clk_cfg_t   cfg, cfg_n;
  req_kind_e  pend, pend_n;
  logic [2:0] pcode, pcode_n;
  logic       wake_n, err_set, stab_load;
  logic       div_tick, any_wake, stab_done, in_pll;

  lpm_divider #(.SLOW_DIV(SLOW_DIV)) u_div (
    .clk(clk), .rst(rst), .run_i(st == ST_RUN), .slow_i(cfg.slow), .tick_o(div_tick)
  );

  lpm_wake_sel #(.NIRQ(NIRQ), .LVL_W(LVL_W)) u_wake (
    .per_irq_i(per_irq_i), .per_lvl_i(per_lvl_i), .gie_i(gie_i),
    .nmi_i(nmi_i), .lvd_i(lvd_irq_i), .any_wake_o(any_wake)
  );

  lpm_stab_timer #(.STAB_W(STAB_W)) u_stab (
    .clk(clk), .rst(rst), .load_i(stab_load), .val_i(stab_cycles_i), .done_o(stab_done)
  );

  assign in_pll = (cfg.src == SRC_PLL);

  always_comb begin
    st_n      = st;
    cfg_n     = cfg;
    pend_n    = pend;
    pcode_n   = pcode;
    wake_n    = 1'b0;
    err_set   = 1'b0;
    stab_load = 1'b0;
    unique case (st)
      ST_RUN: begin
        if (div_tick && pend != RQ_NONE) begin
          pend_n = RQ_NONE;
          unique case (pend)
            RQ_MODE: begin
              if (pcode == MODE_HS) begin
                cfg_n = '{src: SRC_MAIN, slow: 1'b0};
              end else if (pcode == MODE_PLL && cfg.src == SRC_MAIN && !cfg.slow) begin
                cfg_n = '{src: SRC_PLL, slow: 1'b0};
              end else if (pcode == MODE_LS && !in_pll) begin
                cfg_n = '{src: SRC_SUB, slow: 1'b0};
              end else if (pcode == MODE_OCO && !in_pll) begin
                cfg_n = '{src: SRC_OCO, slow: 1'b0};
              end else if (pcode == MODE_MED && !in_pll) begin
                cfg_n = '{src: SRC_MAIN, slow: 1'b1};
              end else begin
                err_set = 1'b1;
              end
            end
            RQ_WAIT: begin
              if (in_pll) err_set = 1'b1;
              else        st_n = ST_WAIT;
            end
            RQ_STOP: begin
              if (in_pll || osc_det_en_i) err_set = 1'b1;
              else                        st_n = ST_STOP;
            end
            default: ;
          endcase
        end else if (stop_req_i) begin
          pend_n = RQ_STOP;
        end else if (wait_req_i) begin
          pend_n = RQ_WAIT;
        end else if (mode_req_valid_i) begin
          pend_n  = RQ_MODE;
          pcode_n = mode_req_code_i;
        end
      end
      ST_WAIT: begin
        if (any_wake) begin
          st_n   = ST_RUN;
          wake_n = 1'b1;
        end
      end
      ST_STOP: begin
        if (any_wake) begin
          st_n       = ST_STAB;
          stab_load  = 1'b1;
          cfg_n.slow = (cfg.src != SRC_SUB);
        end
      end
      ST_STAB: begin
        if (stab_done) begin
          st_n   = ST_RUN;
          wake_n = 1'b1;
        end
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_RUN;
      cfg           <= '{src: SRC_MAIN, slow: 1'b1};
      pend          <= RQ_NONE;
      pcode         <= '0;
      main_osc_en_o <= 1'b1;
      sub_osc_en_o  <= 1'b0;
      oco_en_o      <= 1'b0;
      pll_en_o      <= 1'b0;
      clk_sel_o     <= SRC_MAIN;
      div_ratio_o   <= DIV_W'(SLOW_DIV);
      cpu_clk_en_o  <= 1'b1;
      wake_o        <= 1'b0;
      illegal_o     <= 1'b0;
    end else begin
      st            <= st_n;
      cfg           <= cfg_n;
      pend          <= pend_n;
      pcode         <= pcode_n;
      main_osc_en_o <= (st_n != ST_STOP) && (cfg_n.src == SRC_MAIN || cfg_n.src == SRC_PLL);
      sub_osc_en_o  <= (st_n != ST_STOP) && (cfg_n.src == SRC_SUB);
      oco_en_o      <= (st_n != ST_STOP) && (cfg_n.src == SRC_OCO);
      pll_en_o      <= (st_n != ST_STOP) && (cfg_n.src == SRC_PLL);
      clk_sel_o     <= cfg_n.src;
      div_ratio_o   <= cfg_n.slow ? DIV_W'(SLOW_DIV) : DIV_W'(1);
      cpu_clk_en_o  <= (st_n == ST_RUN);
      wake_o        <= wake_n;
      illegal_o     <= err_set | (illegal_o & ~err_clr_i);
    end
  end
endmodule

// File: rtl/lpm_clkctl_chk.sv
module lpm_clkctl_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             main_osc_en_o,
  input logic             sub_osc_en_o,
  input logic             oco_en_o,
  input logic             pll_en_o,
  input logic [1:0]       clk_sel_o,
  input logic [DIV_W-1:0] div_ratio_o,
  input logic             cpu_clk_en_o,
  input logic             wake_o,
  input logic             illegal_o,
  input logic             err_clr_i
);
  // R2: PLL needs its reference oscillator running
  assert_pll_ref_R2: assert property (@(posedge clk) disable iff (rst)
    pll_en_o |-> main_osc_en_o);

  // R2: PLL is entered only from main/1
  assert_pll_entry_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en_o) |-> ($past(clk_sel_o) == 2'd0 && $past(div_ratio_o) == DIV_W'(1)));

  // R8: wake event coincides with the gate reopening and lasts one cycle
  assert_wake_on_open_R8: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $rose(cpu_clk_en_o));
  assert_wake_single_R8: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);

  // R8: gate still closed when oscillators restart after stop
  assert_gate_held_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!main_osc_en_o && !sub_osc_en_o && !oco_en_o && !pll_en_o) &&
     (main_osc_en_o || sub_osc_en_o || oco_en_o)) |-> !cpu_clk_en_o);

  // R9: gate closes only after a divided-clock boundary
  assert_gate_fall_tick_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_clk_en_o) |-> $past(tick_i));

  // R9: source or ratio changes under an open gate only after a boundary
  assert_cfg_change_tick_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en_o && $past(cpu_clk_en_o) &&
     ($past(clk_sel_o) != clk_sel_o || $past(div_ratio_o) != div_ratio_o)) |-> $past(tick_i));

  // R10: error flag holds until cleared
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (illegal_o && !err_clr_i) |=> illegal_o);
endmodule

bind lpm_clkctl lpm_clkctl_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst(rst), .tick_i(div_tick),
  .main_osc_en_o(main_osc_en_o), .sub_osc_en_o(sub_osc_en_o),
  .oco_en_o(oco_en_o), .pll_en_o(pll_en_o), .clk_sel_o(clk_sel_o),
  .div_ratio_o(div_ratio_o), .cpu_clk_en_o(cpu_clk_en_o), .wake_o(wake_o),
  .illegal_o(illegal_o), .err_clr_i(err_clr_i)
);

// File: tb/lpm_clkctl_tb_top.sv
module lpm_clkctl_tb_top;
  localparam int NIRQ = 4, LVL_W = 3, STAB_W = 8, SLOW_DIV = 8;
  localparam int DIV_W = $clog2(SLOW_DIV + 1);
  localparam int SETTLE = 2 * SLOW_DIV + 4;

  logic clk = 1'b0, rst = 1'b1;
  logic stop_req = 0, wait_req = 0, mode_valid = 0;
  logic [2:0] mode_code = '0;
  logic nmi = 0, lvd = 0, gie = 0, det_en = 0, err_clr = 0;
  logic [NIRQ-1:0] irq = '0;
  logic [NIRQ*LVL_W-1:0] lvl = '0;
  logic [STAB_W-1:0] stab = '0;
  logic main_en, sub_en, oco_en, pll_en, gate, wake, illegal;
  logic [1:0] sel;
  logic [DIV_W-1:0] ratio;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lpm_clkctl #(.NIRQ(NIRQ), .LVL_W(LVL_W), .STAB_W(STAB_W), .SLOW_DIV(SLOW_DIV)) dut_i (
    .clk(clk), .rst(rst), .stop_req_i(stop_req), .wait_req_i(wait_req),
    .mode_req_valid_i(mode_valid), .mode_req_code_i(mode_code), .nmi_i(nmi),
    .lvd_irq_i(lvd), .per_irq_i(irq), .per_lvl_i(lvl), .gie_i(gie),
    .osc_det_en_i(det_en), .err_clr_i(err_clr), .stab_cycles_i(stab),
    .main_osc_en_o(main_en), .sub_osc_en_o(sub_en), .oco_en_o(oco_en),
    .pll_en_o(pll_en), .clk_sel_o(sel), .div_ratio_o(ratio),
    .cpu_clk_en_o(gate), .wake_o(wake), .illegal_o(illegal)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic req_mode(input logic [2:0] code);
    @(negedge clk); mode_valid = 1; mode_code = code;
    @(negedge clk); mode_valid = 0;
    settle();
  endtask

  task automatic req_wait();
    @(negedge clk); wait_req = 1;
    @(negedge clk); wait_req = 0;
    settle();
  endtask

  task automatic req_stop();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    settle();
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic check_reset_state(input string tag);
    check(tag, "sel", sel, 0);
    check(tag, "ratio", ratio, 8);
    check(tag, "osc enables {main,sub,oco,pll}", {main_en, sub_en, oco_en, pll_en}, 4'b1000);
    check(tag, "gate", gate, 1);
    check(tag, "wake", wake, 0);
    check(tag, "error", illegal, 0);
  endtask

  task automatic t_reset();
    check_reset_state("R1");
  endtask

  task automatic t_modes();
    req_mode(3'd0);
    check("R2", "HS sel", sel, 0); check("R2", "HS ratio", ratio, 1);
    req_mode(3'd1);
    check("R2", "PLL sel", sel, 3); check("R2", "PLL en", pll_en, 1);
    check("R2", "PLL main en", main_en, 1); check("R2", "PLL ratio", ratio, 1);
    req_mode(3'd2);
    check("R5", "PLL->LS refused sel", sel, 3); check("R10", "error set", illegal, 1);
    clear_err();
    @(negedge clk);
    check("R10", "error cleared", illegal, 0);
    req_mode(3'd0);
    check("R2", "PLL->HS sel", sel, 0); check("R2", "PLL off", pll_en, 0);
    req_mode(3'd3);
    check("R2", "OCO sel", sel, 2); check("R2", "OCO en", oco_en, 1);
    check("R2", "OCO main off", main_en, 0);
    req_mode(3'd1);
    check("R2", "OCO->PLL refused sel", sel, 2); check("R2", "OCO->PLL error", illegal, 1);
    clear_err();
    req_mode(3'd6);
    check("R2", "code 6 refused sel", sel, 2); check("R2", "code 6 error", illegal, 1);
    // R10: refusal in the same cycle as a clear keeps the flag set
    @(negedge clk); mode_valid = 1; mode_code = 3'd7;
    @(negedge clk); mode_valid = 0; err_clr = 1;
    @(negedge clk); err_clr = 0;
    settle();
    check("R10", "set wins over clear", illegal, 1);
    clear_err();
    req_mode(3'd4);
    check("R2", "MED sel", sel, 0); check("R2", "MED ratio", ratio, 8);
    check("R10", "error stays cleared", illegal, 0);
  endtask

  task automatic t_boundary();
    int n;
    req_mode(3'd0);
    @(negedge clk); mode_valid = 1; mode_code = 3'd4;
    n = 0;
    do begin @(negedge clk); mode_valid = 0; n++; end while (ratio != 8 && n < 20);
    mode_valid = 1; mode_code = 3'd0;
    n = 0;
    do begin @(negedge clk); mode_valid = 0; n++; end while (ratio == 8 && n < 30);
    check("R9", "edges until change in divide-by-8 mode", n, 8);
  endtask

  task automatic t_wait();
    req_mode(3'd0);
    req_wait();
    check("R3", "gate closed in wait", gate, 0);
    check("R3", "main osc kept", main_en, 1);
    check("R3", "sel kept", sel, 0);
    @(negedge clk); irq[0] = 1; lvl[2:0] = 3'd0; gie = 1;
    repeat (4) @(negedge clk);
    check("R6", "level-0 irq ignored", gate, 0);
    lvl[2:0] = 3'd3; gie = 0;
    repeat (4) @(negedge clk);
    check("R6", "gie low irq ignored", gate, 0);
    gie = 1;
    @(negedge clk);
    check("R3", "gate reopened", gate, 1);
    check("R3", "wake pulse", wake, 1);
    check("R3", "ratio kept", ratio, 1);
    irq = '0; lvl = '0; gie = 0;
    @(negedge clk);
    check("R3", "wake one cycle", wake, 0);
  endtask

  task automatic t_pll_refusals();
    req_mode(3'd0);
    req_mode(3'd1);
    req_wait();
    check("R5", "wait from PLL gate", gate, 1);
    check("R5", "wait from PLL sel", sel, 3);
    check("R5", "wait from PLL error", illegal, 1);
    clear_err();
    req_stop();
    check("R5", "stop from PLL pll en", pll_en, 1);
    check("R5", "stop from PLL gate", gate, 1);
    check("R5", "stop from PLL error", illegal, 1);
    clear_err();
    req_mode(3'd0);
    det_en = 1;
    req_stop();
    check("R5", "stop with detect gate", gate, 1);
    check("R5", "stop with detect main en", main_en, 1);
    check("R5", "stop with detect error", illegal, 1);
    det_en = 0;
    clear_err();
  endtask

  // kind: 0 = NMI, 1 = low-voltage, 2 = peripheral
  task automatic t_stop(input logic [2:0] mode, input int kind, input int st_cnt,
                        input int exp_sel, input int exp_ratio, input logic [2:0] exp_osc);
    int n;
    req_mode(mode);
    stab = STAB_W'(st_cnt);
    req_stop();
    check("R4", "stop osc enables", {main_en, sub_en, oco_en, pll_en}, 0);
    check("R4", "stop gate", gate, 0);
    @(negedge clk); irq[2] = 1; lvl[8:6] = 3'd0; gie = 1;
    repeat (3) @(negedge clk);
    check("R6", "level-0 irq keeps stop", {main_en, sub_en, oco_en}, 0);
    irq = '0; gie = 0;
    @(negedge clk);
    case (kind)
      0: nmi = 1;
      1: lvd = 1;
      default: begin irq[1] = 1; lvl[5:3] = 3'd5; gie = 1; end
    endcase
    @(negedge clk);
    nmi = 0; lvd = 0; irq = '0; lvl = '0; gie = 0;
    check("R7", "wake osc {main,sub,oco}", {main_en, sub_en, oco_en}, exp_osc);
    check("R7", "wake sel", sel, exp_sel);
    check("R7", "wake ratio", ratio, exp_ratio);
    check("R8", "gate closed at osc start", gate, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!gate && n < 300);
    check("R8", "cycles until gate reopens", n, st_cnt + 1);
    check("R8", "wake at reopen", wake, 1);
    @(negedge clk);
    check("R8", "wake one cycle", wake, 0);
  endtask

  task automatic t_reset_from_low_power();
    req_mode(3'd0);
    req_stop();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    check_reset_state("R11");
    req_mode(3'd3);
    req_wait();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    check_reset_state("R11");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_modes();
    t_boundary();
    t_wait();
    t_pll_refusals();
    t_stop(3'd0, 0, 3, 0, 8, 3'b100);
    t_stop(3'd2, 2, 5, 1, 1, 3'b010);
    t_stop(3'd3, 1, 0, 2, 8, 3'b001);
    t_reset_from_low_power();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule